// File: doc/BRIEF.md
# Frame Buffer Fetch Address Generator

This block produces the read addresses a display controller needs to pull one frame out of a linear frame buffer in memory. Software programs four values through a small write-only register port: a start address, an end address, the number of halfwords that are visible on each line, and the number of halfwords to skip after each line. The skip value lets the stored line be wider than the visible line. All addresses are in halfword units, that is, byte addresses shifted right by one.

Once enabled, the block issues 32-bit word read requests on a valid/acknowledge port. Each accepted request moves the pointer on by two halfwords. At the end of a visible line the pointer jumps over the unused tail of the stored line. When the pointer after a line reaches the end address, the block pulses a frame-done flag and starts again at the start address. The frame is kept inside one aligned region: only the low address bits count, and the high bits are taken from the start register. The first request of a frame carries a start-of-frame flag, and the last request of each line carries an end-of-line flag.

Values written while a frame is being fetched are held back until the next frame begins. Software must keep the start address, page width and offset even, and must set the end address to start plus stride times line count. The pixel width must already be rounded up so that each line is a whole number of halfwords.

Top module: `fb_fetch_agen`

## Requirements
- R1: After reset, req_valid, req_sof, req_eol and frame_done are low, the enable bit is clear, and no request is issued until the enable bit is written to 1.
- R2: Register index 0 bit 0 is the enable bit. Index 1 holds the start halfword address in bits [HADDR_W-1:0]. Index 2 holds the low REGION_W bits of the end halfword address. Index 3 holds the page width in halfwords in bits [WIDTH_W-1:0] and the line-skip offset in halfwords in bits [16+OFFS_W-1:16]. A write lands on the rising edge where cfg_we is high.
- R3: The first request of every frame addresses the start address and has req_sof high. req_sof is low on every other request.
- R4: Inside a line, each accepted request is followed by a request two halfwords higher. A line takes page width / 2 requests, and only the last of them has req_eol high.
- R5: After the end-of-line request is accepted, the next address is that address plus 2 plus the offset.
- R6: When the address that follows an accepted end-of-line request equals the end address (low REGION_W bits), frame_done is high for exactly the next cycle, and the next request is a new frame that begins at the start address.
- R7: Address bits above REGION_W stay equal to those of the start address for the whole frame. The low REGION_W bits wrap modulo 2^REGION_W.
- R8: While req_valid is high and req_ack is low, req_valid stays high and req_haddr, req_sof and req_eol keep their values.
- R9: When the enable bit is cleared, a request that is already pending stays valid until it is accepted, and no further request follows. Enabling again restarts at the start address with req_sof high.
- R10: Writes to the start, end, width or offset registers made during a frame do not change that frame. They take effect at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Register index |
| cfg_wdata | input | DATA_W | Register write data |
| req_valid | output | 1 | Read request valid |
| req_haddr | output | HADDR_W | Request address in halfwords (always even) |
| req_ack | input | 1 | Memory accepts the request this cycle |
| req_sof | output | 1 | Request is the first of a frame |
| req_eol | output | 1 | Request is the last of a visible line |
| frame_done | output | 1 | One-cycle pulse after the last request of a frame is accepted |

## Verification
The bench builds the block with a 16-bit halfword address, a 6-bit region (64 halfwords), and 8-bit width and offset fields. With the small region, frames that start near the top of the region cross the modulo-64 boundary, which shows that the high bits stay fixed and the low bits wrap. Frames are also short enough that many random geometries, each with several frame wraps, fit into the run. Random acknowledge gaps exercise the hold behaviour. Directed phases cover a register write in the middle of a frame and a disable while a request is waiting.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_BASE  = 2'd1,
    REG_LIMIT = 2'd2,
    REG_LINE  = 2'd3
  } fbf_reg_e;

  localparam int LINE_OFFS_LSB = 16;
  localparam int WORD_HW       = 2;
endpackage

// File: rtl/fbf_cfg_regs.sv
module fbf_cfg_regs
  import fbf_pkg::*;
#(
  parameter int HADDR_W  = 31,
  parameter int REGION_W = 21,
  parameter int WIDTH_W  = 12,
  parameter int OFFS_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [1:0]          idx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                capture,
  output logic                en,
  output logic [HADDR_W-1:0]  live_base,
  output logic [WIDTH_W-1:0]  live_width,
  output logic [REGION_W-1:0] sh_limit,
  output logic [WIDTH_W-1:0]  sh_width,
  output logic [OFFS_W-1:0]   sh_offs
);
  logic [REGION_W-1:0] live_limit;
  logic [OFFS_W-1:0]   live_offs;

  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b0;
      live_base  <= '0;
      live_limit <= '0;
      live_width <= '0;
      live_offs  <= '0;
    end else if (we) begin
      case (fbf_reg_e'(idx))
        REG_CTRL:  en         <= wdata[0];
        REG_BASE:  live_base  <= wdata[HADDR_W-1:0];
        REG_LIMIT: live_limit <= wdata[REGION_W-1:0];
        REG_LINE: begin
          live_width <= wdata[WIDTH_W-1:0];
          live_offs  <= wdata[LINE_OFFS_LSB+OFFS_W-1:LINE_OFFS_LSB];
        end
        default: ;
      endcase
    end
  end

  // Frame-time copy: only refreshed when the walker starts a frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_limit <= '0;
      sh_width <= '0;
      sh_offs  <= '0;
    end else if (capture) begin
      sh_limit <= live_limit;
      sh_width <= live_width;
      sh_offs  <= live_offs;
    end
  end

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !capture |=> ($stable(sh_limit) && $stable(sh_width) && $stable(sh_offs)));
endmodule

// File: rtl/fbf_step.sv
module fbf_step
  import fbf_pkg::*;
#(
  parameter int REGION_W = 21,
  parameter int WIDTH_W  = 12,
  parameter int OFFS_W   = 12
) (
  input  logic [REGION_W-1:0] ptr,
  input  logic [WIDTH_W-1:0]  col,
  input  logic [WIDTH_W-1:0]  width,
  input  logic [OFFS_W-1:0]   offs,
  input  logic [REGION_W-1:0] limit,
  output logic [REGION_W-1:0] nxt_ptr,
  output logic [WIDTH_W-1:0]  nxt_col,
  output logic                line_end,
  output logic                frame_end,
  output logic                nxt_eol
);
  localparam int SUM_W = ((REGION_W > OFFS_W) ? REGION_W : OFFS_W) + 2;
  localparam int CW    = WIDTH_W + 1;

  logic [SUM_W-1:0] plain_sum;
  logic [SUM_W-1:0] skip_sum;
  logic [CW-1:0]    col_inc;
  logic [CW-1:0]    nxt_inc;

  always_comb begin
    col_inc   = CW'(col) + CW'(WORD_HW);
    line_end  = (col_inc == CW'(width));
    plain_sum = SUM_W'(ptr) + SUM_W'(WORD_HW);
    skip_sum  = plain_sum + SUM_W'(offs);
    nxt_ptr   = line_end ? skip_sum[REGION_W-1:0] : plain_sum[REGION_W-1:0];
    nxt_col   = line_end ? '0 : col_inc[WIDTH_W-1:0];
    frame_end = line_end && (nxt_ptr == limit);
    nxt_inc   = CW'(nxt_col) + CW'(WORD_HW);
    nxt_eol   = (nxt_inc == CW'(width));
  end
endmodule

// File: rtl/fbf_walker.sv
module fbf_walker
  import fbf_pkg::*;
#(
  parameter int HADDR_W  = 31,
  parameter int REGION_W = 21,
  parameter int WIDTH_W  = 12,
  parameter int OFFS_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [HADDR_W-1:0]  live_base,
  input  logic [WIDTH_W-1:0]  live_width,
  input  logic [REGION_W-1:0] sh_limit,
  input  logic [WIDTH_W-1:0]  sh_width,
  input  logic [OFFS_W-1:0]   sh_offs,
  input  logic                req_ack,
  output logic                capture,
  output logic                req_valid,
  output logic [HADDR_W-1:0]  req_haddr,
  output logic                req_sof,
  output logic                req_eol,
  output logic                frame_done
);
  localparam int HI_W = HADDR_W - REGION_W;

  logic                run;
  logic [REGION_W-1:0] ptr;
  logic [HI_W-1:0]     hi;
  logic [WIDTH_W-1:0]  col;
  logic [REGION_W-1:0] nxt_ptr;
  logic [WIDTH_W-1:0]  nxt_col;
  logic                line_end, frame_end, nxt_eol;
  logic                accept, start_idle, first_eol;

  fbf_step #(
    .REGION_W (REGION_W),
    .WIDTH_W  (WIDTH_W),
    .OFFS_W   (OFFS_W)
  ) u_step (
    .ptr       (ptr),
    .col       (col),
    .width     (sh_width),
    .offs      (sh_offs),
    .limit     (sh_limit),
    .nxt_ptr   (nxt_ptr),
    .nxt_col   (nxt_col),
    .line_end  (line_end),
    .frame_end (frame_end),
    .nxt_eol   (nxt_eol)
  );

  assign accept     = req_valid && req_ack;
  assign start_idle = !run && en;
  assign capture    = start_idle || (run && accept && frame_end);
  assign first_eol  = (live_width == WIDTH_W'(WORD_HW));
  assign req_haddr  = {hi, ptr};

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      ptr        <= '0;
      hi         <= '0;
      col        <= '0;
      req_valid  <= 1'b0;
      req_sof    <= 1'b0;
      req_eol    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (start_idle) begin
        run       <= 1'b1;
        ptr       <= live_base[REGION_W-1:0];
        hi        <= live_base[HADDR_W-1:REGION_W];
        col       <= '0;
        req_valid <= 1'b1;
        req_sof   <= 1'b1;
        req_eol   <= first_eol;
      end else if (run && accept) begin
        req_sof <= 1'b0;
        if (frame_end) begin
          frame_done <= 1'b1;
          ptr        <= live_base[REGION_W-1:0];
          hi         <= live_base[HADDR_W-1:REGION_W];
          col        <= '0;
          req_sof    <= 1'b1;
          req_eol    <= first_eol;
        end else begin
          ptr     <= nxt_ptr;
          col     <= nxt_col;
          req_eol <= nxt_eol;
        end
        if (!en) begin
          run       <= 1'b0;
          req_valid <= 1'b0;
          req_sof   <= 1'b0;
          req_eol   <= 1'b0;
        end
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_haddr) && $stable(req_sof) && $stable(req_eol)));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_eol) |=> (req_haddr[REGION_W-1:0] == REGION_W'($past(req_haddr[REGION_W-1:0]) + REGION_W'(WORD_HW))));

  assert_region_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_eol) |=> $stable(req_haddr[HADDR_W-1:REGION_W]));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_sof_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_done && req_valid) |-> req_sof);

  assert_sof_once_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && req_sof) |=> (!req_sof || frame_done));

  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && !req_valid) |=> !req_valid);
endmodule

// File: rtl/fb_fetch_agen.sv
module fb_fetch_agen #(
  parameter int HADDR_W  = 31,
  parameter int REGION_W = 21,
  parameter int WIDTH_W  = 12,
  parameter int OFFS_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_idx,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic               req_valid,
  output logic [HADDR_W-1:0] req_haddr,
  input  logic               req_ack,
  output logic               req_sof,
  output logic               req_eol,
  output logic               frame_done
);
  logic                en;
  logic                capture;
  logic [HADDR_W-1:0]  live_base;
  logic [WIDTH_W-1:0]  live_width;
  logic [REGION_W-1:0] sh_limit;
  logic [WIDTH_W-1:0]  sh_width;
  logic [OFFS_W-1:0]   sh_offs;

  fbf_cfg_regs #(
    .HADDR_W  (HADDR_W),
    .REGION_W (REGION_W),
    .WIDTH_W  (WIDTH_W),
    .OFFS_W   (OFFS_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .idx        (cfg_idx),
    .wdata      (cfg_wdata),
    .capture    (capture),
    .en         (en),
    .live_base  (live_base),
    .live_width (live_width),
    .sh_limit   (sh_limit),
    .sh_width   (sh_width),
    .sh_offs    (sh_offs)
  );

  fbf_walker #(
    .HADDR_W  (HADDR_W),
    .REGION_W (REGION_W),
    .WIDTH_W  (WIDTH_W),
    .OFFS_W   (OFFS_W)
  ) u_walk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .live_base  (live_base),
    .live_width (live_width),
    .sh_limit   (sh_limit),
    .sh_width   (sh_width),
    .sh_offs    (sh_offs),
    .req_ack    (req_ack),
    .capture    (capture),
    .req_valid  (req_valid),
    .req_haddr  (req_haddr),
    .req_sof    (req_sof),
    .req_eol    (req_eol),
    .frame_done (frame_done)
  );
endmodule

// File: tb/fb_fetch_agen_bench.sv
module fb_fetch_agen_bench;
  localparam int HW = 16, RW = 6, WW = 8, OW = 8, DW = 32;
  localparam int RMASK = (1 << RW) - 1;

  logic clk = 1'b0, rst = 1'b1, cfg_we = 1'b0, req_ack = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic req_valid, req_sof, req_eol, frame_done;
  logic [HW-1:0] req_haddr;

  always #5 clk = ~clk;

  fb_fetch_agen #(.HADDR_W(HW), .REGION_W(RW), .WIDTH_W(WW), .OFFS_W(OW), .DATA_W(DW))
  u_fb_fetch_agen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_haddr(req_haddr), .req_ack(req_ack),
    .req_sof(req_sof), .req_eol(req_eol), .frame_done(frame_done)
  );

  int checks = 0, fails = 0;
  bit hold = 1'b1;
  // live model registers
  bit m_en = 0; int m_base = 0, m_limit = 0, m_width = 0, m_offs = 0;
  // frame-time model copy
  int s_base = 0, s_limit = 0, s_width = 0, s_offs = 0;
  int m_ptr = 0, m_col = 0, kind = 0, m_frames = 0, r10_win = 0;
  bit m_run = 0, m_sof = 0, exp_done = 0, r7_mode = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic capture_model();
    s_base = m_base; s_limit = m_limit; s_width = m_width; s_offs = m_offs;
  endtask

  always @(negedge clk) begin
    bit ack;
    string tag;
    int np, expa;
    if (!rst) begin
      chk(frame_done == exp_done, "R6", frame_done, exp_done);
      if (exp_done) m_frames++;
      exp_done = 0;
      if (!m_run && req_valid) begin
        if (!m_en) chk(0, "R9", 1, 0);
        capture_model();
        m_ptr = s_base & RMASK; m_col = 0; m_run = 1; m_sof = 1; kind = 0;
      end
      ack = 0;
      if (m_run) begin
        if (r10_win > 0) tag = "R10";
        else if (r7_mode) tag = "R7";
        else if (kind == 0) tag = "R3";
        else if (kind == 1) tag = "R5";
        else tag = "R4";
        expa = ((s_base >> RW) << RW) | m_ptr;
        chk(req_valid == 1'b1, "R8", req_valid, 1);
        chk(req_haddr == HW'(expa), tag, req_haddr, expa);
        chk(req_sof == m_sof, "R3", req_sof, m_sof);
        chk(req_eol == (m_col + 2 == s_width), "R4", req_eol, (m_col + 2 == s_width));
        if (r10_win > 0) r10_win--;
        ack = !hold && ($urandom_range(3) != 0);
        if (ack) begin
          m_sof = 0;
          if (m_col + 2 == s_width) begin
            np = (m_ptr + 2 + s_offs) & RMASK; m_col = 0; kind = 1;
            if (np == s_limit) begin
              exp_done = 1; capture_model(); np = s_base & RMASK; m_sof = 1; kind = 0;
            end
          end else begin
            np = (m_ptr + 2) & RMASK; m_col += 2; kind = 2;
          end
          m_ptr = np;
          if (!m_en) m_run = 0;
        end
      end
      req_ack = ack;
    end
  end

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(i); cfg_wdata = d;
    case (i)
      0: m_en = d[0];
      1: m_base = int'(d[HW-1:0]);
      2: m_limit = int'(d[RW-1:0]);
      default: begin m_width = int'(d[WW-1:0]); m_offs = int'(d[16+OW-1:16]); end
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int hi, input int lo, input int w, input int o, input int h);
    wr(1, 32'((hi << RW) | lo));
    wr(2, 32'((lo + (w + o) * h) & RMASK));
    wr(3, 32'((o << 16) | w));
  endtask

  task automatic wait_frames(input int n);
    int t = m_frames + n;
    while (m_frames < t) @(negedge clk);
  endtask

  task automatic stop_run();
    hold = 1; repeat (2) @(negedge clk);
    wr(0, 0);
    repeat (3) @(negedge clk);
    hold = 0; repeat (6) @(negedge clk);
    chk(req_valid == 1'b0, "R9", req_valid, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=hung expected=frames_done");
    summary();
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h1d2c);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_valid == 0, "R1", req_valid, 0);
    chk(req_sof == 0, "R1", req_sof, 0);
    chk(req_eol == 0, "R1", req_eol, 0);
    chk(frame_done == 0, "R1", frame_done, 0);
    setup(10'h012, 4, 6, 4, 3);
    repeat (5) @(negedge clk);
    chk(req_valid == 0, "R1", req_valid, 0);
    wr(0, 1);
    repeat (3) @(negedge clk);
    chk(req_haddr[HW-1:RW] == 10'h012, "R2", req_haddr[HW-1:RW], 10'h012);
    hold = 0;
    wait_frames(3);
    // mid-frame write of a new line shape with the same stride
    hold = 1; repeat (2) @(negedge clk);
    wr(3, 32'((6 << 16) | 4));
    r10_win = 8;
    hold = 0;
    wait_frames(3);
    stop_run();
    repeat (5) @(negedge clk);
    chk(req_valid == 0, "R9", req_valid, 0);
    // frame crossing the modulo region boundary
    setup(10'h2c5, 56, 4, 2, 3);
    r7_mode = 1;
    wr(0, 1);
    repeat (3) @(negedge clk);
    chk(req_haddr[HW-1:RW] == 10'h2c5, "R7", req_haddr[HW-1:RW], 10'h2c5);
    wait_frames(3);
    r7_mode = 0;
    stop_run();
    for (int i = 0; i < 12; i++) begin
      int w, o, s, h, hmax, lo, hi;
      w = 2 * (1 + $urandom_range(7));
      o = 2 * $urandom_range(4);
      s = w + o;
      hmax = 63 / s; if (hmax > 4) hmax = 4;
      h = 1 + $urandom_range(hmax - 1);
      lo = 2 * $urandom_range(31);
      hi = $urandom_range(1023);
      hold = 1;
      setup(hi, lo, w, o, h);
      wr(0, 1);
      hold = 0;
      wait_frames(2);
      stop_run();
    end
    summary();
    $finish;
  end
endmodule